// File: doc/BRIEF.md
# Wake-up Mode Power Controller

This block sequences a network controller into and out of a low-activity wake-up mode and reports a wake event. While the mode is active it holds three gating outputs high: one stops new bus-master transfers, one stops new transmits and one tells the receive path to discard incoming frames. Register reads and writes from the host are not touched by the block and stay available.

Entry follows a fixed order. The controller must already be suspended, the mode-select bit must be set while no trigger is present, and only then may a trigger arrive. The trigger is either the active-low sleep pin (hardware) or the software enable bit. The mode ends as soon as the trigger is withdrawn. A detect pulse from the pattern detector sets a sticky status flag, which can drive an interrupt request and an LED. The flag is cleared with a write-one-to-clear strobe. After the hardware trigger is withdrawn, the pin must stay deasserted for a minimum off-time before a new assertion counts. The software trigger has no such rule.

There is no data stream through this block, so every pin is a plain level or strobe and none uses a handshake.

Top module: `wake_power_ctrl`

## Requirements
- R1: After reset, block_master_o, block_tx_o, flush_rx_o, status_o and irq_o are 0, and led_o sits at its inactive level, which is the inverse of led_pol_i.
- R2: The mode is entered only if three conditions are met in order. First, suspended_i=1 and mode_sel_i=1 hold together for at least one clock while no trigger is present. Second, both still hold. Third, a trigger then appears. A trigger that is already present when the two conditions first come true, or that arrives while either condition is 0, does not enter the mode.
- R3: While the mode is active, block_master_o, block_tx_o and flush_rx_o are all 1. Outside the mode they are all 0.
- R4: The mode ends in the cycle after the trigger is withdrawn, and dropping suspended_i or mode_sel_i alone does not end it. If suspended_i and mode_sel_i are still 1, setting sw_enable_i again re-enters the mode on the next clock edge.
- R5: sleep_n_i (0 = sleep requested) passes through a two-flop synchroniser. A falling pin enters the mode 4 clock edges after it is sampled, and a rising pin ends the mode 4 edges after it is sampled.
- R6: A falling sleep_n_i counts as a trigger only if the synchronised pin was high for at least OFF_CYCLES consecutive cycles before the fall (default 7). An earlier fall is ignored until the pin rises again.
- R7: A detect_i pulse while the mode is active sets status_o on the next edge. status_o stays set after the mode ends. A detect_i pulse outside the mode is ignored.
- R8: irq_o equals status_o AND gie_i AND wie_i.
- R9: led_o shows led_sel_i AND status_o. It is active high when led_pol_i=1 and active low when led_pol_i=0.
- R10: clr_status_i=1 clears status_o on the next edge, and irq_o follows it low. If a detect and a clear arrive in the same cycle, the detect wins.
- R11: After a detection, all three gating outputs stay 1 until the trigger is withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| suspended_i | input | 1 | Controller has finished its suspend |
| mode_sel_i | input | 1 | Wake-up mode select bit |
| sw_enable_i | input | 1 | Software trigger bit |
| sleep_n_i | input | 1 | Asynchronous sleep pin, active low |
| detect_i | input | 1 | One-cycle detect pulse from the pattern detector |
| gie_i | input | 1 | Global interrupt enable |
| wie_i | input | 1 | Wake interrupt enable |
| led_sel_i | input | 1 | Route the wake status to the LED |
| led_pol_i | input | 1 | LED polarity, 1 = active high |
| clr_status_i | input | 1 | Write-one-to-clear strobe for the status flag |
| block_master_o | output | 1 | Stop new bus-master transfers |
| block_tx_o | output | 1 | Stop new transmits |
| flush_rx_o | output | 1 | Discard received frames |
| status_o | output | 1 | Sticky wake status flag |
| irq_o | output | 1 | Interrupt request |
| led_o | output | 1 | LED drive |

## Verification
The assertions assume the following about the inputs:
- detect_i and clr_status_i are synchronous strobes.
- sleep_n_i may change at any time, because only its synchronised copy reaches the checked logic.
- Apart from the pin, the control bits are stable levels sampled at the clock.

The stimulus keeps to these rules. It drives every input at the falling edge, holds each level for whole cycles and pulses the strobes for exactly one cycle. It also holds the sleep pin low long enough for the synchroniser latency before it samples any mode output.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [1:0] {
    WK_IDLE   = 2'd0,
    WK_ARMED  = 2'd1,
    WK_ACTIVE = 2'd2
  } wake_state_t;
endpackage

// File: rtl/wake_pin_filter.sv
module wake_pin_filter #(
  parameter int OFF_CYCLES = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_n_i,
  output logic hw_trig_o
);
  localparam int CW = $clog2(OFF_CYCLES + 1);
  localparam logic [CW-1:0] CMAX = CW'(OFF_CYCLES);

  logic          s1, s2;
  logic [CW-1:0] high_cnt;
  logic          hw_trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= sleep_n_i;
      s2 <= s1;
    end
  end

  // High-time counter saturates at the off-time; a fall latches the trigger
  // only when the counter had reached its limit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_cnt <= CMAX;
      hw_trig  <= 1'b0;
    end else if (s2) begin
      if (high_cnt != CMAX) high_cnt <= high_cnt + CW'(1);
      hw_trig <= 1'b0;
    end else begin
      high_cnt <= '0;
      if (!hw_trig && high_cnt == CMAX) hw_trig <= 1'b1;
    end
  end

  assign hw_trig_o = hw_trig;

  // R6
  trig_needs_offtime_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hw_trig) |-> $past(high_cnt) == CMAX);

  // R5
  trig_only_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(s2) |-> !hw_trig);
endmodule

// File: rtl/wake_mode_fsm.sv
module wake_mode_fsm
  import wake_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic suspended_i,
  input  logic mode_sel_i,
  input  logic sw_enable_i,
  input  logic hw_trig_i,
  output logic active_o
);
  wake_state_t state, state_nx;
  logic prep, trig;

  assign prep = suspended_i & mode_sel_i;
  assign trig = sw_enable_i | hw_trig_i;

  always_comb begin
    state_nx = state;
    unique case (state)
      WK_IDLE:   if (prep && !trig) state_nx = WK_ARMED;
      WK_ARMED:  if (!prep) state_nx = WK_IDLE;
                 else if (trig) state_nx = WK_ACTIVE;
      WK_ACTIVE: if (!trig) state_nx = prep ? WK_ARMED : WK_IDLE;
      default:   state_nx = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= WK_IDLE;
    else        state <= state_nx;
  end

  assign active_o = (state == WK_ACTIVE);

  // R2
  entry_from_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> ($past(state) == WK_ARMED) && $past(prep) && $past(trig));

  // R4
  exit_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !trig) |=> !active_o);

  // R4
  hold_while_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && trig) |=> active_o);
endmodule

// File: rtl/wake_report.sv
module wake_report (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic detect_i,
  input  logic clr_i,
  input  logic gie_i,
  input  logic wie_i,
  input  logic led_sel_i,
  input  logic led_pol_i,
  output logic status_o,
  output logic irq_o,
  output logic led_o
);
  logic status, set_ev, show;

  assign set_ev = detect_i & active_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      status <= 1'b0;
    else if (set_ev) status <= 1'b1;
    else if (clr_i)  status <= 1'b0;
  end

  assign show     = led_sel_i & status;
  assign led_o    = led_pol_i ? show : ~show;
  assign irq_o    = status & gie_i & wie_i;
  assign status_o = status;

  // R7
  detect_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> status_o);

  // R7
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_o && !active_i) |=> !status_o);

  // R10
  clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_ev) |=> !status_o);

  // R10
  irq_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o) |-> !irq_o);
endmodule

// File: rtl/wake_power_ctrl.sv
module wake_power_ctrl #(
  parameter int OFF_CYCLES = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic suspended_i,
  input  logic mode_sel_i,
  input  logic sw_enable_i,
  input  logic sleep_n_i,
  input  logic detect_i,
  input  logic gie_i,
  input  logic wie_i,
  input  logic led_sel_i,
  input  logic led_pol_i,
  input  logic clr_status_i,
  output logic block_master_o,
  output logic block_tx_o,
  output logic flush_rx_o,
  output logic status_o,
  output logic irq_o,
  output logic led_o
);
  logic hw_trig, active;

  wake_pin_filter #(.OFF_CYCLES(OFF_CYCLES)) u_pin (
    .clk(clk), .rst_n(rst_n), .sleep_n_i(sleep_n_i), .hw_trig_o(hw_trig)
  );

  wake_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .suspended_i(suspended_i), .mode_sel_i(mode_sel_i),
    .sw_enable_i(sw_enable_i), .hw_trig_i(hw_trig), .active_o(active)
  );

  wake_report u_rep (
    .clk(clk), .rst_n(rst_n), .active_i(active), .detect_i(detect_i),
    .clr_i(clr_status_i), .gie_i(gie_i), .wie_i(wie_i), .led_sel_i(led_sel_i),
    .led_pol_i(led_pol_i), .status_o(status_o), .irq_o(irq_o), .led_o(led_o)
  );

  assign block_master_o = active;
  assign block_tx_o     = active;
  assign flush_rx_o     = active;

  // R11
  gate_held_after_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && detect_i && sw_enable_i) |=> block_tx_o);
endmodule

// File: tb/sim_wake_power_ctrl.sv
module sim_wake_power_ctrl;
  localparam int OFF = 7;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic suspended = 0, mode_sel = 0, sw_en = 0, sleep_n = 1, detect = 0;
  logic gie = 0, wie = 0, led_sel = 0, led_pol = 0, clr = 0;
  logic blk_m, blk_tx, flush, status, irq, led;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  wake_power_ctrl #(.OFF_CYCLES(OFF)) u0 (
    .clk(clk), .rst_n(rst_n), .suspended_i(suspended), .mode_sel_i(mode_sel),
    .sw_enable_i(sw_en), .sleep_n_i(sleep_n), .detect_i(detect), .gie_i(gie),
    .wie_i(wie), .led_sel_i(led_sel), .led_pol_i(led_pol), .clr_status_i(clr),
    .block_master_o(blk_m), .block_tx_o(blk_tx), .flush_rx_o(flush),
    .status_o(status), .irq_o(irq), .led_o(led)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic chk_gate(input string tag, input logic exp);
    chk(tag, blk_m, exp);
    chk(tag, blk_tx, exp);
    chk(tag, flush, exp);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk_gate("R1", 1'b0);
    chk("R1 status", status, 1'b0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 led", led, ~led_pol);

    // R2: trigger present before the preparation steps -> no entry
    sw_en = 1; step(1);
    suspended = 1; mode_sel = 1; step(4);
    chk_gate("R2 early trigger", 1'b0);
    // correct order
    sw_en = 0; step(1);
    sw_en = 1; step(1);
    chk_gate("R2 R3 ordered entry", 1'b1);
    // R4: drop of preparation alone keeps the mode
    suspended = 0; mode_sel = 0; step(2);
    chk_gate("R4 prep drop holds", 1'b1);
    suspended = 1; mode_sel = 1; step(1);
    sw_en = 0; step(1);
    chk_gate("R4 exit", 1'b0);
    sw_en = 1; step(1);
    chk_gate("R4 immediate re-enable", 1'b1);
    sw_en = 0; step(1);

    // R2: missing suspend or missing mode select
    suspended = 0; step(2);
    sw_en = 1; step(3);
    chk_gate("R2 no suspend", 1'b0);
    sw_en = 0; suspended = 1; mode_sel = 0; step(2);
    sw_en = 1; step(3);
    chk_gate("R2 no mode_sel", 1'b0);
    sw_en = 0; mode_sel = 1; step(2);

    // R7: detect outside the mode is ignored
    detect = 1; step(1); detect = 0;
    chk("R7 ignored outside", status, 1'b0);

    // R7 R8 R9 R10 R11 sweep over all enable / LED settings
    for (int c = 0; c < 16; c++) begin
      {gie, wie, led_sel, led_pol} = 4'(c);
      sw_en = 1; step(1);
      detect = 1; step(1); detect = 0;
      chk("R7 set", status, 1'b1);
      chk("R8 irq", irq, gie & wie);
      chk("R9 led", led, led_pol ? led_sel : ~led_sel);
      step(2);
      chk_gate("R11 held after detect", 1'b1);
      sw_en = 0; step(1);
      chk_gate("R11 exit after detect", 1'b0);
      chk("R7 sticky", status, 1'b1);
      clr = 1; step(1); clr = 0;
      chk("R10 cleared", status, 1'b0);
      chk("R10 irq low", irq, 1'b0);
      chk("R9 led idle", led, ~led_pol);
    end

    // R10: set wins over clear
    gie = 1; wie = 1;
    sw_en = 1; step(1);
    detect = 1; clr = 1; step(1); detect = 0; clr = 0;
    chk("R10 set priority", status, 1'b1);
    chk("R8 irq on", irq, 1'b1);
    clr = 1; step(1); clr = 0;
    chk("R10 clear", status, 1'b0);
    sw_en = 0; step(2);

    // R5: hardware path latency
    sleep_n = 0; step(3);
    chk_gate("R5 not yet", 1'b0);
    step(1);
    chk_gate("R5 entry", 1'b1);
    sleep_n = 1; step(3);
    chk_gate("R5 still on", 1'b1);
    step(1);
    chk_gate("R5 exit", 1'b0);
    step(10);

    // R6: off-time sweep
    sleep_n = 0; step(6);
    chk_gate("R6 start", 1'b1);
    for (int n = 1; n <= 10; n++) begin
      sleep_n = 1; step(n);
      sleep_n = 0; step(6);
      chk_gate("R6 off-time", (n >= OFF) ? 1'b1 : 1'b0);
    end
    sleep_n = 1; step(6);
    chk_gate("R6 end", 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule